// File: doc/BRIEF.md
# Word-Size-Aware FIFO Pair with Threshold Interrupts

This block holds the two data queues that sit between a serial shift engine and the register bus of a serial peripheral controller. Each direction owns a fixed byte capacity (16 bytes by default). That capacity is carved into 16, 8 or 4 entries, depending on whether words are 8, 16 or 32 bits wide. The bus side writes words for transmission and reads received words. The shift engine takes transmit words and delivers received words.

Each queue drives its own level-sensitive interrupt request. A 2-bit trigger mode selects the condition for each request. The requests are a pure function of the current fill level, the mode and the shift engine's idle state, so they rise and fall with the level. Both fill levels are reported as 5-bit entry counts for a status register. A sticky overflow flag records a received word that arrived while the receive queue had no room. Changing the word size, or dropping the module enable, empties both queues.

Bus writes, bus reads and engine transmit pops use valid/ready handshakes. A transfer happens on a rising clock edge where both are high. The producer must hold valid and data until ready is seen, and ready never depends on valid. The block's output valids depend only on its own state and the enable and word-size inputs, so the data at the head of a queue stays steady until it is taken. The engine's received word is a strobe with no ready, because the serial line cannot be stalled. When the queue is full the word is dropped and flagged.

Top module: `fifo_irq_gen`

## Requirements
- R1: The queue capacity in entries is 16 for word_size 0 (8-bit), 8 for word_size 1 (16-bit) and 4 for word_size 2 or 3 (32-bit). bus_wr_ready is high exactly when the block is live and the transmit level is below that capacity. "Live" means enable is high and word_size equals its value in the previous cycle.
- R2: Each queue returns words in arrival order. bus_rd_data and eng_tx_data present the head word with only the low 8, 16 or 32 bits kept for the current word size, and the bits above cleared. bus_rd_valid and eng_tx_valid are high exactly when the block is live and the matching queue is not empty.
- R3: rx_irq follows irq_cfg[1:0] while live. Mode 0 fires when the receive queue is empty. Mode 1 fires when it is not empty. Mode 2 fires when the level is at least half the capacity. Mode 3 fires when the level equals the capacity.
- R4: tx_irq follows irq_cfg[3:2] while live. Mode 0 fires when the transmit queue is empty and shift_busy is low. Mode 1 fires when the queue is empty. Mode 2 fires when the free entries are at least half the capacity. Mode 3 fires when at least one entry is free.
- R5: tx_level and rx_level are 5-bit entry counts that change on the clock edge of a handshake. A push and a pop in the same cycle leave the level unchanged. Both levels are 0 after reset.
- R6: A word that arrives from the engine (eng_rx_valid while live) when the receive level equals the capacity is discarded, even if the bus reads in the same cycle. It sets rx_overflow on that edge, and the queue contents are kept.
- R7: In a cycle where word_size differs from its previous value, both queues are emptied on the next edge. In that cycle no handshake is accepted, no engine word is taken, and both interrupt requests are low.
- R8: While enable is low, both queues are emptied, every ready and valid output is low, both interrupt requests are low, and engine words are ignored without touching rx_overflow.
- R9: rx_overflow stays set until a cycle with ovf_clr high and no new overflow. When a set and a clear fall in the same cycle, the set wins.
- R10: The interrupt requests are not latched. When the level leaves a mode's condition, the request drops in the same cycle as the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Module enable; low flushes and halts both queues |
| word_size | input | 2 | 0: 8-bit, 1: 16-bit, 2/3: 32-bit words |
| irq_cfg | input | 4 | [1:0] receive trigger mode, [3:2] transmit trigger mode |
| shift_busy | input | 1 | Shift register holds an unfinished transmit word |
| ovf_clr | input | 1 | Clears rx_overflow |
| bus_wr_valid | input | 1 | Bus offers a transmit word |
| bus_wr_data | input | 32 | Transmit word from the bus |
| bus_wr_ready | output | 1 | Transmit queue accepts the word |
| eng_tx_valid | output | 1 | Transmit head word available to the engine |
| eng_tx_data | output | 32 | Transmit head word, masked to word size |
| eng_tx_ready | input | 1 | Engine takes the transmit head word |
| eng_rx_valid | input | 1 | Engine finished receiving a word (strobe) |
| eng_rx_data | input | 32 | Received word from the engine |
| bus_rd_valid | output | 1 | Receive head word available to the bus |
| bus_rd_data | output | 32 | Receive head word, masked to word size |
| bus_rd_ready | input | 1 | Bus takes the receive head word |
| tx_level | output | 5 | Transmit entries in use |
| rx_level | output | 5 | Receive entries in use |
| rx_overflow | output | 1 | Sticky receive overflow flag |
| tx_irq | output | 1 | Transmit threshold interrupt request |
| rx_irq | output | 1 | Receive threshold interrupt request |

## Verification
Levels and the overflow flag are registered and move one clock edge after the cycle holding the handshake, the arrival, the flush condition or the clear. Ready, valid, head data and both interrupt requests are combinational from that state and the present inputs, so they are due in the same cycle. The bench drives every input on the falling edge and compares all outputs one nanosecond later against a queue model that matches the state after the last rising edge. Only then does it advance the model with the inputs just applied, so each result is checked in the cycle it is due. Directed runs cover full and empty at 32-bit words, overflow with a clear in the same cycle, a word-size change with data held, disable, and an interrupt falling with the level. A long biased random run alternates fill and drain phases so that every trigger mode meets its edge cases.

// File: rtl/fifo_thr_pkg.sv
package fifo_thr_pkg;

  typedef enum logic [1:0] {
    WSZ_8   = 2'd0,
    WSZ_16  = 2'd1,
    WSZ_32  = 2'd2,
    WSZ_32X = 2'd3
  } wsize_e;

  // Entries available in a queue of 'bytes' bytes for a given word size.
  function automatic int unsigned entries_for(input logic [1:0] ws, input int unsigned bytes);
    case (wsize_e'(ws))
      WSZ_8:   return bytes;
      WSZ_16:  return bytes / 2;
      default: return bytes / 4;
    endcase
  endfunction

  // Lanes kept for a given word size; upper lanes read as zero.
  function automatic logic [31:0] lane_mask(input logic [1:0] ws);
    case (wsize_e'(ws))
      WSZ_8:   return 32'h0000_00FF;
      WSZ_16:  return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int SLOTS = 16,
  parameter int DW    = 32,
  parameter int LW    = $clog2(SLOTS) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [LW-1:0] limit,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [LW-1:0] level
);
  localparam int AW = $clog2(SLOTS);

  logic [DW-1:0] mem [SLOTS];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] cnt;

  // Pointers wrap at the active entry count, not at the physical slot count.
  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p, input logic [LW-1:0] lim);
    logic [LW-1:0] nx;
    nx = LW'(p) + LW'(1);
    return (nx == lim) ? '0 : nx[AW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr, limit);
      if (pop)  rd_ptr <= bump(rd_ptr, limit);
      if (push && !pop)      cnt <= cnt + LW'(1);
      else if (pop && !push) cnt <= cnt - LW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= push_data;
  end

  assign head  = mem[rd_ptr];
  assign level = cnt;
endmodule

// File: rtl/fifo_irq_thresh.sv
module fifo_irq_thresh #(
  parameter int LW    = 5,
  parameter bit IS_TX = 1'b0
) (
  input  logic          live,
  input  logic [1:0]    mode,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] limit,
  input  logic          idle,
  output logic          irq
);
  logic [LW-1:0] half;
  logic          drained;
  logic          hit;

  assign half    = limit >> 1;
  assign drained = (level == '0) && idle;

  generate
    if (IS_TX) begin : g_tx
      always_comb begin
        case (mode)
          2'd0:    hit = drained;
          2'd1:    hit = (level == '0);
          2'd2:    hit = ((limit - level) >= half);
          default: hit = (level < limit);
        endcase
      end
    end else begin : g_rx
      always_comb begin
        case (mode)
          2'd0:    hit = drained;
          2'd1:    hit = (level != '0);
          2'd2:    hit = (level >= half);
          default: hit = (level == limit);
        endcase
      end
    end
  endgenerate

  assign irq = live && hit;
endmodule

// File: rtl/fifo_irq_gen.sv
module fifo_irq_gen
  import fifo_thr_pkg::*;
#(
  parameter int BYTES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic [1:0]  word_size,
  input  logic [3:0]  irq_cfg,
  input  logic        shift_busy,
  input  logic        ovf_clr,
  input  logic        bus_wr_valid,
  input  logic [31:0] bus_wr_data,
  output logic        bus_wr_ready,
  output logic        eng_tx_valid,
  output logic [31:0] eng_tx_data,
  input  logic        eng_tx_ready,
  input  logic        eng_rx_valid,
  input  logic [31:0] eng_rx_data,
  output logic        bus_rd_valid,
  output logic [31:0] bus_rd_data,
  input  logic        bus_rd_ready,
  output logic [4:0]  tx_level,
  output logic [4:0]  rx_level,
  output logic        rx_overflow,
  output logic        tx_irq,
  output logic        rx_irq
);
  localparam int LW = $clog2(BYTES) + 1;
  localparam int DW = 32;

  logic [1:0]    ws_q;
  logic          live, flush;
  logic [LW-1:0] limit;
  logic [LW-1:0] tx_cnt, rx_cnt;
  logic [DW-1:0] tx_head, rx_head, mask;
  logic          tx_push, tx_pop, rx_push, rx_pop, rx_arrive, rx_full, ovf_set;
  logic          ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ws_q <= WSZ_8;
    else        ws_q <= word_size;
  end

  assign live  = enable && (word_size == ws_q);
  assign flush = !live;
  assign limit = LW'(entries_for(word_size, BYTES));
  assign mask  = lane_mask(word_size);

  assign bus_wr_ready = live && (tx_cnt < limit);
  assign eng_tx_valid = live && (tx_cnt != '0);
  assign bus_rd_valid = live && (rx_cnt != '0);

  assign tx_push   = bus_wr_valid && bus_wr_ready;
  assign tx_pop    = eng_tx_valid && eng_tx_ready;
  assign rx_pop    = bus_rd_valid && bus_rd_ready;
  assign rx_arrive = eng_rx_valid && live;
  assign rx_full   = (rx_cnt == limit);
  assign rx_push   = rx_arrive && !rx_full;
  assign ovf_set   = rx_arrive && rx_full;

  fifo_store #(.SLOTS(BYTES), .DW(DW), .LW(LW)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush), .limit(limit),
    .push(tx_push), .push_data(bus_wr_data), .pop(tx_pop),
    .head(tx_head), .level(tx_cnt)
  );

  fifo_store #(.SLOTS(BYTES), .DW(DW), .LW(LW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush), .limit(limit),
    .push(rx_push), .push_data(eng_rx_data), .pop(rx_pop),
    .head(rx_head), .level(rx_cnt)
  );

  fifo_irq_thresh #(.LW(LW), .IS_TX(1'b1)) u_tx_thr (
    .live(live), .mode(irq_cfg[3:2]), .level(tx_cnt), .limit(limit),
    .idle(!shift_busy), .irq(tx_irq)
  );

  fifo_irq_thresh #(.LW(LW), .IS_TX(1'b0)) u_rx_thr (
    .live(live), .mode(irq_cfg[1:0]), .level(rx_cnt), .limit(limit),
    .idle(1'b1), .irq(rx_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_q <= 1'b0;
    else if (ovf_set) ovf_q <= 1'b1;
    else if (ovf_clr) ovf_q <= 1'b0;
  end

  assign eng_tx_data = tx_head & mask;
  assign bus_rd_data = rx_head & mask;
  assign tx_level    = 5'(tx_cnt);
  assign rx_level    = 5'(rx_cnt);
  assign rx_overflow = ovf_q;
endmodule

// File: rtl/fifo_irq_chk.sv
module fifo_irq_chk
  import fifo_thr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic [1:0] word_size,
  input logic       eng_rx_valid,
  input logic       bus_wr_ready,
  input logic       bus_rd_valid,
  input logic       eng_tx_valid,
  input logic [4:0] tx_level,
  input logic [4:0] rx_level,
  input logic       rx_overflow,
  input logic       tx_irq,
  input logic       rx_irq
);
  logic [1:0] ws_seen;
  logic [4:0] lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ws_seen <= 2'd0;
    else        ws_seen <= word_size;
  end

  assign lim = 5'(entries_for(word_size, 16));

  // R1
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_size == ws_seen) |-> (tx_level <= lim && rx_level <= lim));

  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && word_size == ws_seen && eng_rx_valid && rx_level == lim) |=> rx_overflow);

  // R6
  ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && word_size == ws_seen && eng_rx_valid && rx_level == lim) |=> (rx_level <= $past(rx_level)));

  // R7
  ws_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_size != ws_seen) |=> (tx_level == 5'd0 && rx_level == 5'd0));

  // R8
  off_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (tx_level == 5'd0 && rx_level == 5'd0));

  // R8
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!tx_irq && !rx_irq && !bus_wr_ready && !bus_rd_valid && !eng_tx_valid));

  // R2
  rd_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_valid |-> (rx_level != 5'd0));
endmodule

bind fifo_irq_gen fifo_irq_chk u_chk (.*);

// File: tb/sim_fifo_irq_gen.sv
`timescale 1ns/1ps
module sim_fifo_irq_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1;
  logic [1:0]  word_size = 2'd0;
  logic [3:0]  irq_cfg = 4'd0;
  logic        shift_busy = 1'b0;
  logic        ovf_clr = 1'b0;
  logic        bus_wr_valid = 1'b0;
  logic [31:0] bus_wr_data = '0;
  logic        eng_tx_ready = 1'b0;
  logic        eng_rx_valid = 1'b0;
  logic [31:0] eng_rx_data = '0;
  logic        bus_rd_ready = 1'b0;
  wire         bus_wr_ready, eng_tx_valid, bus_rd_valid, rx_overflow, tx_irq, rx_irq;
  wire [31:0]  eng_tx_data, bus_rd_data;
  wire [4:0]   tx_level, rx_level;

  int checks = 0;
  int fails  = 0;

  logic [31:0] txq[$];
  logic [31:0] rxq[$];
  bit          ovf_m = 1'b0;
  logic [1:0]  ws_prev = 2'd0;

  always #10 clk = ~clk;

  fifo_irq_gen u0 (.*);

  function automatic int depth_f(input logic [1:0] ws);
    return (ws == 2'd0) ? 16 : (ws == 2'd1) ? 8 : 4;
  endfunction

  function automatic logic [31:0] mask_f(input logic [1:0] ws);
    return (ws == 2'd0) ? 32'hFF : (ws == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic bit rx_irq_f(input int m, input int lvl, input int d);
    case (m)
      0: return lvl == 0;
      1: return lvl != 0;
      2: return lvl >= d / 2;
      default: return lvl == d;
    endcase
  endfunction

  function automatic bit tx_irq_f(input int m, input int lvl, input int d, input bit busy);
    case (m)
      0: return (lvl == 0) && !busy;
      1: return lvl == 0;
      2: return (d - lvl) >= d / 2;
      default: return lvl < d;
    endcase
  endfunction

  task automatic chk(input string ph, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", ph, what, act, exp);
    end
  endtask

  // Inputs were set at the falling edge; compare, then advance the model.
  task automatic step(input string ph);
    int d;
    bit fl, txr, txv, rdv, full;
    #1;
    d   = depth_f(word_size);
    fl  = !enable || (word_size != ws_prev);
    txr = !fl && (txq.size() < d);
    txv = !fl && (txq.size() > 0);
    rdv = !fl && (rxq.size() > 0);
    chk(ph, "R5 tx_level", tx_level, txq.size());
    chk(ph, "R5 rx_level", rx_level, rxq.size());
    chk(ph, "R1 bus_wr_ready", bus_wr_ready, txr);
    chk(ph, "R2 eng_tx_valid", eng_tx_valid, txv);
    chk(ph, "R2 bus_rd_valid", bus_rd_valid, rdv);
    chk(ph, "R3 rx_irq", rx_irq, !fl && rx_irq_f(irq_cfg[1:0], rxq.size(), d));
    chk(ph, "R4 tx_irq", tx_irq, !fl && tx_irq_f(irq_cfg[3:2], txq.size(), d, shift_busy));
    chk(ph, "R6 rx_overflow", rx_overflow, ovf_m);
    if (txv && eng_tx_valid) chk(ph, "R2 eng_tx_data", eng_tx_data, txq[0] & mask_f(word_size));
    if (rdv && bus_rd_valid) chk(ph, "R2 bus_rd_data", bus_rd_data, rxq[0] & mask_f(word_size));
    if (fl) begin
      txq.delete();
      rxq.delete();
      if (ovf_clr) ovf_m = 1'b0;
    end else begin
      full = (rxq.size() == d);
      if (txv && eng_tx_ready) void'(txq.pop_front());
      if (txr && bus_wr_valid) txq.push_back(bus_wr_data);
      if (rdv && bus_rd_ready) void'(rxq.pop_front());
      if (eng_rx_valid && full) ovf_m = 1'b1;
      else begin
        if (eng_rx_valid) rxq.push_back(eng_rx_data);
        if (ovf_clr) ovf_m = 1'b0;
      end
    end
    ws_prev = word_size;
    @(negedge clk);
  endtask

  task automatic idle_in();
    bus_wr_valid = 0; eng_tx_ready = 0; eng_rx_valid = 0; bus_rd_ready = 0; ovf_clr = 0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step("RST R5");

    // R1 R2: 32-bit words, fill transmit queue past capacity, then drain
    word_size = 2'd2; irq_cfg = 4'b1110;
    step("R7 ws");
    bus_wr_valid = 1;
    for (int i = 0; i < 6; i++) begin bus_wr_data = 32'hA500_0000 + i; step("R1 fill"); end
    bus_wr_valid = 0; eng_tx_ready = 1;
    for (int i = 0; i < 5; i++) step("R2 drain");
    idle_in();

    // R6 R9: overflow at full receive queue, then clear arbitration
    irq_cfg = 4'b0011;
    eng_rx_valid = 1;
    for (int i = 0; i < 6; i++) begin eng_rx_data = 32'h5A00_0010 + i; step("R6 ovf"); end
    eng_rx_valid = 1; ovf_clr = 1; step("R9 set-wins");
    eng_rx_valid = 0; step("R9 clear");
    ovf_clr = 0; bus_rd_ready = 1;
    for (int i = 0; i < 5; i++) step("R6 kept");
    idle_in();

    // R10: not-empty trigger drops with the level
    irq_cfg = 4'b0001; eng_rx_valid = 1; eng_rx_data = 32'h1234_5678; step("R10 push");
    eng_rx_valid = 0; bus_rd_ready = 1; step("R10 pop");
    bus_rd_ready = 0; step("R10 low");

    // R7: word-size change with data held; 8-bit masking
    bus_wr_valid = 1; bus_wr_data = 32'hDEAD_BEEF; eng_rx_valid = 1; eng_rx_data = 32'hCAFE_F00D;
    step("R7 load"); step("R7 load");
    idle_in(); word_size = 2'd0; eng_rx_valid = 1; step("R7 change");
    eng_rx_valid = 1; eng_rx_data = 32'h0000_1234; step("R7 after"); idle_in(); step("R2 mask");

    // R8: disable flushes, ignores engine words
    bus_wr_valid = 1; step("R8 load");
    enable = 0; eng_rx_valid = 1; step("R8 off"); step("R8 off");
    enable = 1; idle_in(); step("R8 back");

    // Biased random run
    for (int i = 0; i < 6000; i++) begin
      bit fillph;
      fillph = ((i / 150) % 2) == 0;
      if (i % 37 == 0) irq_cfg = 4'($urandom);
      shift_busy   = ($urandom % 4) == 0;
      if ($urandom % 90 == 0) word_size = 2'($urandom);
      enable       = ($urandom % 70) != 0;
      bus_wr_valid = fillph ? ($urandom % 10 < 7) : ($urandom % 10 < 2);
      bus_wr_data  = $urandom;
      eng_tx_ready = fillph ? ($urandom % 10 < 2) : ($urandom % 10 < 7);
      eng_rx_valid = fillph ? ($urandom % 10 < 7) : ($urandom % 10 < 2);
      eng_rx_data  = $urandom;
      bus_rd_ready = fillph ? ($urandom % 10 < 2) : ($urandom % 10 < 7);
      ovf_clr      = ($urandom % 16) == 0;
      step("RND");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule